// File: doc/BRIEF.md
# NAND Interface Timing Calculator

This block converts a set of minimum NAND interface timings, given in picoseconds, into the cycle counts that a static-memory NAND bus controller is programmed with. The controller clock period is supplied in whole nanoseconds. A one-cycle `start` pulse captures all inputs. The block then works out six timing fields one after another on a single shared sequential divider. Each result is rounded up to whole clock cycles. Each field then gets its own adjustment: minus one, a floor of one, or saturation at its own width.

The results are presented as two words. The first is a 32-bit common-timing word holding the high-Z, hold, wait and setup counts. The second is a 17-bit control-delay word that carries the CLE-to-RE and ALE-to-RE counts at the bit positions the control register expects. When the parameter set is not usable, the block raises a reject flag and leaves both words as they were. Every run ends with a one-cycle `done` pulse.

The controller is a state machine with five states:
- `S_IDLE`: waits for `start` and captures the inputs.
- `S_CHECK`: validates the captured inputs.
- `S_LOAD`: issues one division.
- `S_DIVIDE`: waits for the quotient and stores the adjusted field.
- `S_FINISH`: publishes the results.

Its transitions are:
- IDLE→CHECK on `start`.
- CHECK→FINISH when the set is rejected, and CHECK→LOAD otherwise.
- LOAD→DIVIDE always.
- DIVIDE→LOAD when a quotient arrives and fields remain.
- DIVIDE→FINISH when the last field's quotient arrives.
- FINISH→IDLE always.

Top module: `nand_timing_calc`

## Requirements
- R1: If the captured read-cycle time is below 30000 ps, or the clock period is 0, the run ends with `done` and `reject`=1, and `timing_word` and `ctl_delays` keep their previous values. A read-cycle time of exactly 30000 ps is accepted.
- R2: `ctl_delays[16:13]` (ALE-to-RE) = min(max(ceil(ns(ale_re_ps)/P) − 1, 0), 15), where ns(x) = floor(x/1000) and P is the period in ns.
- R3: `ctl_delays[12:9]` (CLE-to-RE) uses the R2 formula applied to `cle_re_ps`. `ctl_delays[8:0]` is always 0.
- R4: `timing_word[31:24]` (high-Z) = min(ceil(ns(d)/P), 255), where d = `ce_setup_ps` − `we_pulse_ps`, or 0 if that difference is negative. This field may be 0.
- R5: `timing_word[23:16]` (hold) = ceil(ns(m)/P), where m is the largest of the six hold/high timings. A result of 0 becomes 1, and the field saturates at 255.
- R6: `timing_word[15:8]` (wait) = ceil(ns(max(`re_pulse_ps`, `we_pulse_ps`))/P) − 1. A result of 0 or less becomes 1, and the field saturates at 255.
- R7: `timing_word[7:0]` (setup) = ceil(ns(max(d, e))/P) − 1, with d as in R4 and e = `ce_access_ps` − `re_access_ps` (floored at 0). A result of 0 or less becomes 1, and the field saturates at 255.
- R8: The picosecond-to-nanosecond step truncates before the ceiling division. For example, 1999 ps counts as 1 ns.
- R9: `done` is high for exactly one cycle per accepted `start`, in the same cycle that the new results appear. `reject` is cleared by a successful run.
- R10: `start` is ignored while a run is in progress, and the inputs are sampled only when a run is accepted. Input changes during a run do not affect its results.
- R11: After reset, `timing_word`, `ctl_delays`, `done` and `reject` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| clk_period_ns | input | PER_W | Controller clock period in ns |
| rd_cycle_ps | input | PS_W | Minimum read cycle time |
| ale_re_ps | input | PS_W | ALE-to-RE delay |
| cle_re_ps | input | PS_W | CLE-to-RE delay |
| ce_setup_ps | input | PS_W | Chip-enable setup |
| we_pulse_ps | input | PS_W | Write pulse width |
| data_hold_ps | input | PS_W | Data hold |
| ce_hold_ps | input | PS_W | Chip-enable hold |
| cle_hold_ps | input | PS_W | CLE hold |
| we_high_ps | input | PS_W | Write-enable high time |
| ale_hold_ps | input | PS_W | ALE hold |
| re_high_ps | input | PS_W | Read-enable high time |
| re_pulse_ps | input | PS_W | Read pulse width |
| ce_access_ps | input | PS_W | Chip-enable access time (max) |
| re_access_ps | input | PS_W | Read-enable access time (max) |
| timing_word | output | 32 | Packed high-Z, hold, wait and setup counts |
| ctl_delays | output | 17 | CLE-to-RE at 12:9, ALE-to-RE at 16:13, other bits 0 |
| done | output | 1 | One-cycle end-of-run pulse |
| reject | output | 1 | Last run rejected the parameter set |

## Verification
Four properties are checked on every cycle:
- every divider quotient is an exact integer quotient of the operands it was given;
- `done` never lasts more than one cycle;
- a rejected run leaves both result words unchanged;
- an accepted run never publishes a zero hold, wait or setup count.

Some behaviours can only be shown by the bench's scenarios:
- the per-field formulas;
- the truncation order;
- saturation at 15 and at 255;
- the 30000 ps acceptance boundary;
- the fact that a `start` pulse or changed inputs in the middle of a run leave that run and the following idle period untouched.

// File: rtl/nt_pkg.sv
package nt_pkg;
    typedef enum logic [2:0] {
        F_ALE   = 3'd0,
        F_CLE   = 3'd1,
        F_HIZ   = 3'd2,
        F_HOLD  = 3'd3,
        F_WAIT  = 3'd4,
        F_SETUP = 3'd5
    } field_e;

    localparam int FIELD_CNT = 6;

    // indices of the captured timing array
    localparam int I_RC  = 0;
    localparam int I_AR  = 1;
    localparam int I_CLR = 2;
    localparam int I_CS  = 3;
    localparam int I_WP  = 4;
    localparam int I_DH  = 5;
    localparam int I_CH  = 6;
    localparam int I_CLH = 7;
    localparam int I_WH  = 8;
    localparam int I_ALH = 9;
    localparam int I_REH = 10;
    localparam int I_RP  = 11;
    localparam int I_CEA = 12;
    localparam int I_REA = 13;
    localparam int TIM_CNT = 14;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_CHECK  = 3'd1,
        S_LOAD   = 3'd2,
        S_DIVIDE = 3'd3,
        S_FINISH = 3'd4
    } state_e;
endpackage

// File: rtl/nt_seq_div.sv
module nt_seq_div #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         valid,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvd_q;
    logic [W-1:0]  dsr_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          valid_q;
    logic [W:0]    shifted;
    logic          fits;

    assign shifted = {rem_q[W-1:0], quo_q[W-1]};
    assign fits    = shifted >= {1'b0, dsr_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quo_q   <= '0;
            dvd_q   <= '0;
            dsr_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (go) begin
            rem_q   <= '0;
            quo_q   <= dividend;
            dvd_q   <= dividend;
            dsr_q   <= divisor;
            cnt_q   <= CW'(W);
            busy_q  <= 1'b1;
            valid_q <= 1'b0;
        end else if (busy_q) begin
            rem_q   <= fits ? (shifted - {1'b0, dsr_q}) : shifted;
            quo_q   <= {quo_q[W-2:0], fits};
            cnt_q   <= cnt_q - CW'(1);
            busy_q  <= (cnt_q != CW'(1));
            valid_q <= (cnt_q == CW'(1));
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign valid    = valid_q;
    assign quotient = quo_q;

    // R2 (ceiling rests on an exact floor quotient of the biased operand)
    quot_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (({W'(0), quo_q} * {W'(0), dsr_q}) <= {W'(0), dvd_q}) &&
                    ((({W'(0), quo_q} + 1'b1) * {W'(0), dsr_q}) > {W'(0), dvd_q}));
endmodule

// File: rtl/nt_operand_sel.sv
module nt_operand_sel
    import nt_pkg::*;
#(
    parameter int PS_W = 20
) (
    input  field_e          fld,
    input  logic [PS_W-1:0] tim [TIM_CNT],
    output logic [PS_W-1:0] sel_ps
);
    function automatic logic [PS_W-1:0] sub_floor(input logic [PS_W-1:0] a,
                                                  input logic [PS_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    function automatic logic [PS_W-1:0] max2(input logic [PS_W-1:0] a,
                                             input logic [PS_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [PS_W-1:0] hold_max;
    logic [PS_W-1:0] cs_gap;
    logic [PS_W-1:0] acc_gap;

    always_comb begin
        hold_max = tim[I_DH];
        hold_max = max2(hold_max, tim[I_CH]);
        hold_max = max2(hold_max, tim[I_CLH]);
        hold_max = max2(hold_max, tim[I_WH]);
        hold_max = max2(hold_max, tim[I_ALH]);
        hold_max = max2(hold_max, tim[I_REH]);
        cs_gap   = sub_floor(tim[I_CS], tim[I_WP]);
        acc_gap  = sub_floor(tim[I_CEA], tim[I_REA]);
        unique case (fld)
            F_ALE:   sel_ps = tim[I_AR];
            F_CLE:   sel_ps = tim[I_CLR];
            F_HIZ:   sel_ps = cs_gap;
            F_HOLD:  sel_ps = hold_max;
            F_WAIT:  sel_ps = max2(tim[I_RP], tim[I_WP]);
            F_SETUP: sel_ps = max2(cs_gap, acc_gap);
            default: sel_ps = '0;
        endcase
    end
endmodule

// File: rtl/nt_field_fix.sv
module nt_field_fix
    import nt_pkg::*;
#(
    parameter int QW = 12
) (
    input  field_e        fld,
    input  logic [QW-1:0] quot,
    output logic [7:0]    value
);
    logic          minus_one;
    logic          floor_one;
    logic [QW-1:0] limit;
    logic [QW-1:0] adj;

    always_comb begin
        minus_one = (fld == F_ALE) || (fld == F_CLE) || (fld == F_WAIT) || (fld == F_SETUP);
        floor_one = (fld == F_HOLD) || (fld == F_WAIT) || (fld == F_SETUP);
        limit     = ((fld == F_ALE) || (fld == F_CLE)) ? QW'(15) : QW'(255);
        adj       = quot;
        if (minus_one) adj = (quot == '0) ? '0 : (quot - QW'(1));
        if (floor_one && (adj == '0)) adj = QW'(1);
        value     = (adj > limit) ? limit[7:0] : adj[7:0];
    end
endmodule

// File: rtl/nand_timing_calc.sv
module nand_timing_calc
    import nt_pkg::*;
#(
    parameter int PS_W      = 20,
    parameter int PER_W     = 8,
    parameter int MIN_RC_PS = 30000,
    parameter int PS_PER_NS = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [PER_W-1:0] clk_period_ns,
    input  logic [PS_W-1:0]  rd_cycle_ps,
    input  logic [PS_W-1:0]  ale_re_ps,
    input  logic [PS_W-1:0]  cle_re_ps,
    input  logic [PS_W-1:0]  ce_setup_ps,
    input  logic [PS_W-1:0]  we_pulse_ps,
    input  logic [PS_W-1:0]  data_hold_ps,
    input  logic [PS_W-1:0]  ce_hold_ps,
    input  logic [PS_W-1:0]  cle_hold_ps,
    input  logic [PS_W-1:0]  we_high_ps,
    input  logic [PS_W-1:0]  ale_hold_ps,
    input  logic [PS_W-1:0]  re_high_ps,
    input  logic [PS_W-1:0]  re_pulse_ps,
    input  logic [PS_W-1:0]  ce_access_ps,
    input  logic [PS_W-1:0]  re_access_ps,
    output logic [31:0]      timing_word,
    output logic [16:0]      ctl_delays,
    output logic             done,
    output logic             reject
);
    localparam int NS_MAX = ((1 << PS_W) - 1) / PS_PER_NS;
    localparam int NS_W   = $clog2(NS_MAX + 1);
    localparam int QW     = ((NS_W > PER_W) ? NS_W : PER_W) + 1;

    state_e           state_q, state_n;
    field_e           fld_q;
    logic [PS_W-1:0]  tim_q [TIM_CNT];
    logic [PS_W-1:0]  tim_in [TIM_CNT];
    logic [PER_W-1:0] per_q;
    logic             bad_q;
    logic [7:0]       stage_q [FIELD_CNT];
    logic [PS_W-1:0]  sel_ps;
    logic [NS_W-1:0]  sel_ns;
    logic [QW-1:0]    dividend;
    logic [QW-1:0]    quot;
    logic             div_go;
    logic             div_valid;
    logic [7:0]       fix_val;
    logic             set_bad;

    assign tim_in[I_RC]  = rd_cycle_ps;
    assign tim_in[I_AR]  = ale_re_ps;
    assign tim_in[I_CLR] = cle_re_ps;
    assign tim_in[I_CS]  = ce_setup_ps;
    assign tim_in[I_WP]  = we_pulse_ps;
    assign tim_in[I_DH]  = data_hold_ps;
    assign tim_in[I_CH]  = ce_hold_ps;
    assign tim_in[I_CLH] = cle_hold_ps;
    assign tim_in[I_WH]  = we_high_ps;
    assign tim_in[I_ALH] = ale_hold_ps;
    assign tim_in[I_REH] = re_high_ps;
    assign tim_in[I_RP]  = re_pulse_ps;
    assign tim_in[I_CEA] = ce_access_ps;
    assign tim_in[I_REA] = re_access_ps;

    assign set_bad  = (tim_q[I_RC] < PS_W'(MIN_RC_PS)) || (per_q == '0);
    assign sel_ns   = NS_W'(sel_ps / PS_W'(PS_PER_NS));
    assign dividend = QW'(sel_ns) + QW'(per_q) - QW'(1);
    assign div_go   = (state_q == S_LOAD);

    nt_operand_sel #(.PS_W(PS_W)) u_sel (
        .fld    (fld_q),
        .tim    (tim_q),
        .sel_ps (sel_ps)
    );

    nt_seq_div #(.W(QW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (dividend),
        .divisor  (QW'(per_q)),
        .valid    (div_valid),
        .quotient (quot)
    );

    nt_field_fix #(.QW(QW)) u_fix (
        .fld   (fld_q),
        .quot  (quot),
        .value (fix_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_n = S_CHECK;
            S_CHECK:  state_n = set_bad ? S_FINISH : S_LOAD;
            S_LOAD:   state_n = S_DIVIDE;
            S_DIVIDE: if (div_valid) state_n = (fld_q == F_SETUP) ? S_FINISH : S_LOAD;
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // datapath: capture, field sequencing, staging
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < TIM_CNT; i++) tim_q[i] <= '0;
            for (int i = 0; i < FIELD_CNT; i++) stage_q[i] <= '0;
            per_q <= '0;
            bad_q <= 1'b0;
            fld_q <= F_ALE;
        end else begin
            if (state_q == S_IDLE && start) begin
                for (int i = 0; i < TIM_CNT; i++) tim_q[i] <= tim_in[i];
                per_q <= clk_period_ns;
            end
            if (state_q == S_CHECK) begin
                bad_q <= set_bad;
                fld_q <= F_ALE;
            end
            if (state_q == S_DIVIDE && div_valid) begin
                stage_q[int'(fld_q)] <= fix_val;
                if (fld_q != F_SETUP) fld_q <= field_e'(fld_q + 3'd1);
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timing_word <= '0;
            ctl_delays  <= '0;
            done        <= 1'b0;
            reject      <= 1'b0;
        end else begin
            done <= (state_q == S_FINISH);
            if (state_q == S_FINISH) begin
                reject <= bad_q;
                if (!bad_q) begin
                    timing_word <= {stage_q[F_HIZ], stage_q[F_HOLD],
                                    stage_q[F_WAIT], stage_q[F_SETUP]};
                    ctl_delays  <= {stage_q[F_ALE][3:0], stage_q[F_CLE][3:0], 9'b0};
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && reject) |-> ($stable(timing_word) && $stable(ctl_delays)));

    // R5
    hold_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reject) |-> (timing_word[23:16] != 8'd0));

    // R6 R7
    wait_setup_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !reject) |-> ((timing_word[15:8] != 8'd0) && (timing_word[7:0] != 8'd0)));
endmodule

// File: tb/test_nand_timing_calc.sv
module test_nand_timing_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  per = '0;
    logic [19:0] t [14];
    logic [31:0] timing_word;
    logic [16:0] ctl_delays;
    logic        done;
    logic        reject;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    // order: rc ar clr cs wp dh ch clh wh alh reh rp cea rea period
    localparam int VTAB [0:4][0:14] = '{
        '{100000, 25000, 20000, 70000, 50000, 20000, 20000, 20000, 30000, 20000, 30000, 50000, 100000, 40000, 10},
        '{ 30000,     0,  1999, 10000, 20000,     0,     0,     0,     0,     0,     0,     0,      0,  5000,  1},
        '{900000,900000,900000,900000,  1000,900000,     0,     0,     0,     0,     0,900000, 900000,  1000,  1},
        '{ 45000, 10000, 10000, 35000, 25000,  5000,  5000, 10000, 15000,  5000, 10000, 25000,  45000, 30000,  7},
        '{200000,100000,100000,150000, 60000, 90000, 10000, 10000, 10000, 10000, 10000,120000, 140000, 20000,255}
    };

    nand_timing_calc i_nand_timing_calc (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_period_ns(per),
        .rd_cycle_ps(t[0]), .ale_re_ps(t[1]), .cle_re_ps(t[2]), .ce_setup_ps(t[3]),
        .we_pulse_ps(t[4]), .data_hold_ps(t[5]), .ce_hold_ps(t[6]), .cle_hold_ps(t[7]),
        .we_high_ps(t[8]), .ale_hold_ps(t[9]), .re_high_ps(t[10]), .re_pulse_ps(t[11]),
        .ce_access_ps(t[12]), .re_access_ps(t[13]),
        .timing_word(timing_word), .ctl_delays(ctl_delays), .done(done), .reject(reject)
    );

    function automatic int cyc(int ps, int p);
        int ns = ps / 1000;
        return (ns + p - 1) / p;
    endfunction
    function automatic int sub0(int a, int b); return (a > b) ? a - b : 0; endfunction
    function automatic int mx(int a, int b);   return (a > b) ? a : b;     endfunction
    function automatic int lim(int v, int top); return (v > top) ? top : v; endfunction
    function automatic int m1(int v);  return (v > 0) ? v - 1 : 0; endfunction
    function automatic int f1(int v);  return (v == 0) ? 1 : v;    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load(int v);
        for (int i = 0; i < 14; i++) t[i] = 20'(VTAB[v][i]);
        per = 8'(VTAB[v][14]);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        if (!done) chk({req, " done timeout"}, 0, 1);
    endtask

    task automatic check_vec(int v);
        int p = VTAB[v][14];
        int gap = sub0(VTAB[v][3], VTAB[v][4]);
        int hmax = mx(mx(mx(VTAB[v][5], VTAB[v][6]), mx(VTAB[v][7], VTAB[v][8])),
                      mx(VTAB[v][9], VTAB[v][10]));
        chk("R2 ale", int'(ctl_delays[16:13]), lim(m1(cyc(VTAB[v][1], p)), 15));
        chk("R3 R8 cle", int'(ctl_delays[12:9]), lim(m1(cyc(VTAB[v][2], p)), 15));
        chk("R3 low bits", int'(ctl_delays[8:0]), 0);
        chk("R4 hiz", int'(timing_word[31:24]), lim(cyc(gap, p), 255));
        chk("R5 hold", int'(timing_word[23:16]), lim(f1(cyc(hmax, p)), 255));
        chk("R6 wait", int'(timing_word[15:8]),
            lim(f1(m1(cyc(mx(VTAB[v][11], VTAB[v][4]), p))), 255));
        chk("R7 setup", int'(timing_word[7:0]),
            lim(f1(m1(cyc(mx(gap, sub0(VTAB[v][12], VTAB[v][13])), p))), 255));
        chk("R1 R9 reject low", int'(reject), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] tw_prev;
        logic [16:0] cd_prev;
        int extra;
        load(0);
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 timing_word", int'(timing_word), 0);
        chk("R11 ctl_delays", int'(ctl_delays), 0);
        chk("R11 done", int'(done), 0);
        chk("R11 reject", int'(reject), 0);
        rst_n = 1'b1;

        for (int v = 0; v < 5; v++) begin
            load(v);
            pulse_start();
            wait_done("R9");
            check_vec(v);
            @(negedge clk);
            chk("R9 done width", int'(done), 0);
        end

        // R1 reject: read cycle one below limit
        tw_prev = timing_word; cd_prev = ctl_delays;
        load(0); t[0] = 20'd29999;
        pulse_start(); wait_done("R1");
        chk("R1 reject rc", int'(reject), 1);
        chk("R1 word kept", int'(timing_word == tw_prev), 1);
        chk("R1 delays kept", int'(ctl_delays == cd_prev), 1);
        // R1 reject: zero period
        load(3); per = 8'd0;
        pulse_start(); wait_done("R1");
        chk("R1 reject period", int'(reject), 1);
        chk("R1 word kept p0", int'(timing_word == tw_prev), 1);

        // R10: mid-run start and input change are ignored
        load(0);
        pulse_start();
        repeat (5) @(negedge clk);
        load(2);
        start = 1'b1; @(negedge clk); start = 1'b0;
        wait_done("R10");
        check_vec(0);
        extra = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk("R10 no queued run", extra, 0);
        chk("R10 result unchanged", int'(timing_word[15:8]), 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule